// File: doc/BRIEF.md
# NAND Timing Quantizer

This block turns nanosecond timing targets for a NAND flash read/write interface into whole controller clock counts. It produces three counts: data setup, data hold and address setup. It also works out how the read-strobe sample-delay line must be driven: a half-period drive flag and a 4-bit delay code.

A single `start` pulse captures every input. A small sequencer then reuses one restoring divider for each ceiling division. When the wanted sample delay is longer than the delay line can give, the sequencer adds data-setup cycles, one per clock, and takes one clock period off the sample delay for each cycle added. The results appear together with a one-cycle `done` strobe and stay unchanged until the next run ends. Only the basic algorithm is implemented: the sample delay comes from a single target value, without using device access-time figures.

Top module: `nand_timing_quantizer`

## Requirements
- R1: While `rstN` is low and after its release, before any run, every result output is 0 and `done` is 0.
- R2: Before conversion, a chip count above 2 adds 10 ns to each of the data setup, data hold and address setup targets. A chip count of exactly 2 adds 5 ns. A count of 0 or 1 adds nothing.
- R3: Each adjusted time t is converted to cycles as ceil(t / `periodNs`) and saturated at 255. Data setup and data hold are then raised to at least 1. Address setup may be 0. `periodNs` must be nonzero.
- R4: `halfPeriod` is 1 exactly when `periodNs` > 16. The delay shift is 4 when `halfPeriod` is 1 and 3 otherwise.
- R5: The sample-delay limit is 0 when `periodNs` > 32. Otherwise it is (15 × `periodNs`) >> shift, capped at 16 ns.
- R6: The loop runs while the sample-delay target exceeds the limit and data setup is below 255. Each pass adds one data-setup cycle and subtracts `periodNs` from the target, clamping at 0. Each pass takes one clock cycle.
- R7: `sampleFactor` = ceil((target << shift) / `periodNs`), computed with the target left by R6 and saturated at 15.
- R8: `done` is high for exactly one cycle. It rises 61 + k rising edges after the edge that samples `start`, where k is the number of R6 passes. The results keep their values at all other times.
- R9: The inputs are sampled only on the edge that accepts `start`. A `start` that arrives while a run is in progress is ignored, and input changes during a run have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion (accepted when idle) |
| periodNs | input | 8 | Controller clock period in ns |
| chipCount | input | 3 | Number of chips sharing the bus |
| dataSetupNs | input | 8 | Data setup target in ns |
| dataHoldNs | input | 8 | Data hold target in ns |
| addrSetupNs | input | 8 | Address setup target in ns |
| sampleDelayNs | input | 8 | Wanted read sample delay in ns |
| dataSetupCyc | output | 8 | Data setup in clock cycles |
| dataHoldCyc | output | 8 | Data hold in clock cycles |
| addrSetupCyc | output | 8 | Address setup in clock cycles |
| halfPeriod | output | 1 | Drive the delay line from half periods |
| sampleFactor | output | 4 | Sample delay code |
| done | output | 1 | One-cycle result-valid strobe |

## Verification
Every result is due in the cycle in which `done` is high. That cycle comes 61 + k edges after the accepting edge, where k is the number of setup-for-delay passes that each vector implies. The bench computes k by hand for every vector. It counts edges from `start` to `done`, so a result that arrives early or late is reported. The bench samples on the falling edge. It also checks `done` one cycle later and again some cycles later, to confirm that the strobe has dropped and the results have held.

// File: rtl/ntq_pkg.sv
package ntq_pkg;
  typedef enum logic [1:0] {
    SEL_DS  = 2'd0,
    SEL_DH  = 2'd1,
    SEL_AS  = 2'd2,
    SEL_SDF = 2'd3
  } opSel_e;

  typedef struct packed {
    logic   latch;
    logic   divGo;
    logic   capture;
    logic   tradeStep;
    opSel_e sel;
  } ctrlStrobe_t;
endpackage

// File: rtl/ntq_divider.sv
module ntq_divider #(
  parameter int NUM_W = 13,
  parameter int DEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quotient
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem;
  logic [CNT_W-1:0] cnt;
  logic             busy;
  logic [DEN_W:0]   shifted;
  logic [DEN_W:0]   diff;
  logic             fits;

  assign shifted = {rem, quotient[NUM_W-1]};
  assign fits    = shifted >= {1'b0, den};
  assign diff    = shifted - {1'b0, den};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rem      <= '0;
      quotient <= '0;
      cnt      <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        rem      <= '0;
        quotient <= num;
        cnt      <= CNT_W'(NUM_W);
        busy     <= 1'b1;
      end else if (busy) begin
        rem      <= fits ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
        quotient <= {quotient[NUM_W-2:0], fits};
        cnt      <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ntq_datapath.sv
module ntq_datapath
  import ntq_pkg::*;
#(
  parameter int NS_W           = 8,
  parameter int CHIP_W         = 3,
  parameter int CYC_W          = 8,
  parameter int SDF_W          = 4,
  parameter int DLL_MAX_PERIOD = 32,
  parameter int DLL_MAX_DELAY  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [NS_W-1:0]   periodNs,
  input  logic [CHIP_W-1:0] chipCount,
  input  logic [NS_W-1:0]   dataSetupNs,
  input  logic [NS_W-1:0]   dataHoldNs,
  input  logic [NS_W-1:0]   addrSetupNs,
  input  logic [NS_W-1:0]   sampleDelayNs,
  output logic              divDone,
  output logic              tradeNeeded,
  output logic [NS_W-1:0]   periodQ,
  output logic [CYC_W-1:0]  dataSetupCyc,
  output logic [CYC_W-1:0]  dataHoldCyc,
  output logic [CYC_W-1:0]  addrSetupCyc,
  output logic              halfPeriod,
  output logic [SDF_W-1:0]  sampleFactor
);
  localparam int SUM_W   = NS_W + 1;
  localparam int DIV_W   = NS_W + 5;
  localparam int PROD_W  = NS_W + SDF_W;
  localparam int CYC_MAX = (1 << CYC_W) - 1;
  localparam int SDF_MAX = (1 << SDF_W) - 1;

  logic [SUM_W-1:0]  adj, dsNsQ, dhNsQ, asNsQ;
  logic [NS_W-1:0]   idealQ;
  logic [CYC_W-1:0]  dsW, dhW, asW;
  logic              halfW;
  logic [2:0]        shiftAmt;
  logic [PROD_W-1:0] prod, prodShift, maxSd;
  logic [DIV_W-1:0]  timeSel, num, quo;
  logic [CYC_W-1:0]  satCyc, minOne;
  logic [SDF_W-1:0]  satSdf;

  // bus-loading relief added to the three interface times
  always_comb begin
    if (chipCount > CHIP_W'(2))       adj = SUM_W'(10);
    else if (chipCount == CHIP_W'(2)) adj = SUM_W'(5);
    else                              adj = '0;
  end

  assign halfW     = periodQ > NS_W'(DLL_MAX_PERIOD / 2);
  assign shiftAmt  = halfW ? 3'd4 : 3'd3;
  assign prod      = PROD_W'(SDF_MAX) * PROD_W'(periodQ);
  assign prodShift = prod >> shiftAmt;

  always_comb begin
    if (periodQ > NS_W'(DLL_MAX_PERIOD))          maxSd = '0;
    else if (prodShift > PROD_W'(DLL_MAX_DELAY))  maxSd = PROD_W'(DLL_MAX_DELAY);
    else                                          maxSd = prodShift;
  end

  assign tradeNeeded = (PROD_W'(idealQ) > maxSd) && (dsW < CYC_W'(CYC_MAX));

  always_comb begin
    unique case (strobe.sel)
      SEL_DS:  timeSel = DIV_W'(dsNsQ);
      SEL_DH:  timeSel = DIV_W'(dhNsQ);
      SEL_AS:  timeSel = DIV_W'(asNsQ);
      default: timeSel = DIV_W'(idealQ) << shiftAmt;
    endcase
  end

  assign num = timeSel + DIV_W'(periodQ) - DIV_W'(1);

  ntq_divider #(.NUM_W(DIV_W), .DEN_W(NS_W)) u_divider (
    .clk      (clk),
    .rstN     (rstN),
    .go       (strobe.divGo),
    .num      (num),
    .den      (periodQ),
    .done     (divDone),
    .quotient (quo)
  );

  assign satCyc = (quo > DIV_W'(CYC_MAX)) ? CYC_W'(CYC_MAX) : quo[CYC_W-1:0];
  assign minOne = (satCyc == '0) ? CYC_W'(1) : satCyc;
  assign satSdf = (quo > DIV_W'(SDF_MAX)) ? SDF_W'(SDF_MAX) : quo[SDF_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodQ      <= '0;
      dsNsQ        <= '0;
      dhNsQ        <= '0;
      asNsQ        <= '0;
      idealQ       <= '0;
      dsW          <= '0;
      dhW          <= '0;
      asW          <= '0;
      dataSetupCyc <= '0;
      dataHoldCyc  <= '0;
      addrSetupCyc <= '0;
      halfPeriod   <= 1'b0;
      sampleFactor <= '0;
    end else begin
      if (strobe.latch) begin
        periodQ <= periodNs;
        dsNsQ   <= SUM_W'(dataSetupNs) + adj;
        dhNsQ   <= SUM_W'(dataHoldNs) + adj;
        asNsQ   <= SUM_W'(addrSetupNs) + adj;
        idealQ  <= sampleDelayNs;
      end
      if (strobe.tradeStep) begin
        dsW    <= dsW + 1'b1;
        idealQ <= (idealQ > periodQ) ? idealQ - periodQ : '0;
      end
      if (strobe.capture) begin
        unique case (strobe.sel)
          SEL_DS: dsW <= minOne;
          SEL_DH: dhW <= minOne;
          SEL_AS: asW <= satCyc;
          default: begin
            dataSetupCyc <= dsW;
            dataHoldCyc  <= dhW;
            addrSetupCyc <= asW;
            halfPeriod   <= halfW;
            sampleFactor <= satSdf;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/ntq_ctrl.sv
module ntq_ctrl
  import ntq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        divDone,
  input  logic        tradeNeeded,
  output ctrlStrobe_t strobe,
  output logic        done,
  output logic        running
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_ISSUE, ST_WAIT, ST_TRADE, ST_FINISH
  } state_e;

  state_e state, stateNext;
  opSel_e selQ, selNext;

  always_comb begin
    stateNext = state;
    selNext   = selQ;
    strobe    = '{latch: 1'b0, divGo: 1'b0, capture: 1'b0,
                  tradeStep: 1'b0, sel: selQ};
    unique case (state)
      ST_IDLE: if (start) begin
        strobe.latch = 1'b1;
        selNext      = SEL_DS;
        stateNext    = ST_ISSUE;
      end
      ST_ISSUE: begin
        strobe.divGo = 1'b1;
        stateNext    = ST_WAIT;
      end
      ST_WAIT: if (divDone) begin
        strobe.capture = 1'b1;
        unique case (selQ)
          SEL_DS:  begin selNext = SEL_DH; stateNext = ST_ISSUE; end
          SEL_DH:  begin selNext = SEL_AS; stateNext = ST_ISSUE; end
          SEL_AS:  stateNext = ST_TRADE;
          default: stateNext = ST_FINISH;
        endcase
      end
      ST_TRADE: begin
        if (tradeNeeded) strobe.tradeStep = 1'b1;
        else begin
          selNext   = SEL_SDF;
          stateNext = ST_ISSUE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      selQ  <= SEL_DS;
    end else begin
      state <= stateNext;
      selQ  <= selNext;
    end
  end

  assign done    = state == ST_FINISH;
  assign running = state != ST_IDLE;
endmodule

// File: rtl/nand_timing_quantizer.sv
module nand_timing_quantizer
  import ntq_pkg::*;
#(
  parameter int NS_W           = 8,
  parameter int CHIP_W         = 3,
  parameter int CYC_W          = 8,
  parameter int SDF_W          = 4,
  parameter int DLL_MAX_PERIOD = 32,
  parameter int DLL_MAX_DELAY  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [NS_W-1:0]   periodNs,
  input  logic [CHIP_W-1:0] chipCount,
  input  logic [NS_W-1:0]   dataSetupNs,
  input  logic [NS_W-1:0]   dataHoldNs,
  input  logic [NS_W-1:0]   addrSetupNs,
  input  logic [NS_W-1:0]   sampleDelayNs,
  output logic [CYC_W-1:0]  dataSetupCyc,
  output logic [CYC_W-1:0]  dataHoldCyc,
  output logic [CYC_W-1:0]  addrSetupCyc,
  output logic              halfPeriod,
  output logic [SDF_W-1:0]  sampleFactor,
  output logic              done
);
  ctrlStrobe_t     strobe;
  logic            divDone;
  logic            tradeNeeded;
  logic            running;
  logic [NS_W-1:0] periodQ;

  ntq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .divDone     (divDone),
    .tradeNeeded (tradeNeeded),
    .strobe      (strobe),
    .done        (done),
    .running     (running)
  );

  ntq_datapath #(
    .NS_W(NS_W), .CHIP_W(CHIP_W), .CYC_W(CYC_W), .SDF_W(SDF_W),
    .DLL_MAX_PERIOD(DLL_MAX_PERIOD), .DLL_MAX_DELAY(DLL_MAX_DELAY)
  ) u_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .periodNs      (periodNs),
    .chipCount     (chipCount),
    .dataSetupNs   (dataSetupNs),
    .dataHoldNs    (dataHoldNs),
    .addrSetupNs   (addrSetupNs),
    .sampleDelayNs (sampleDelayNs),
    .divDone       (divDone),
    .tradeNeeded   (tradeNeeded),
    .periodQ       (periodQ),
    .dataSetupCyc  (dataSetupCyc),
    .dataHoldCyc   (dataHoldCyc),
    .addrSetupCyc  (addrSetupCyc),
    .halfPeriod    (halfPeriod),
    .sampleFactor  (sampleFactor)
  );
endmodule

// File: rtl/ntq_checker.sv
module ntq_checker #(
  parameter int NS_W           = 8,
  parameter int CYC_W          = 8,
  parameter int SDF_W          = 4,
  parameter int DLL_MAX_PERIOD = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             done,
  input logic             running,
  input logic [NS_W-1:0]  periodQ,
  input logic [CYC_W-1:0] dataSetupCyc,
  input logic [CYC_W-1:0] dataHoldCyc,
  input logic [CYC_W-1:0] addrSetupCyc,
  input logic             halfPeriod,
  input logic [SDF_W-1:0] sampleFactor
);
  localparam int MIN_LAT = 4 * (NS_W + 5 + 2);

  logic [9:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runCnt <= '0;
    else if (start && !running) runCnt <= '0;
    else if (running && runCnt != '1) runCnt <= runCnt + 1'b1;
  end

  assert_one_cycle_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable({dataSetupCyc, dataHoldCyc, addrSetupCyc, halfPeriod, sampleFactor}));

  assert_min_latency_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> runCnt >= 10'(MIN_LAT));

  assert_min_cycles_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (dataSetupCyc != '0) && (dataHoldCyc != '0));

  assert_slow_clock_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && periodQ > NS_W'(DLL_MAX_PERIOD)) |->
      (sampleFactor == '0) || (dataSetupCyc == '1));
endmodule

bind nand_timing_quantizer ntq_checker #(
  .NS_W(NS_W), .CYC_W(CYC_W), .SDF_W(SDF_W), .DLL_MAX_PERIOD(DLL_MAX_PERIOD)
) u_ntqChecker (
  .clk          (clk),
  .rstN         (rstN),
  .start        (start),
  .done         (done),
  .running      (running),
  .periodQ      (periodQ),
  .dataSetupCyc (dataSetupCyc),
  .dataHoldCyc  (dataHoldCyc),
  .addrSetupCyc (addrSetupCyc),
  .halfPeriod   (halfPeriod),
  .sampleFactor (sampleFactor)
);

// File: tb/nand_timing_quantizer_bench.sv
module nand_timing_quantizer_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [7:0] periodNs = 8'd10;
  logic [2:0] chipCount = '0;
  logic [7:0] dataSetupNs = '0, dataHoldNs = '0, addrSetupNs = '0, sampleDelayNs = '0;
  logic [7:0] dataSetupCyc, dataHoldCyc, addrSetupCyc;
  logic       halfPeriod;
  logic [3:0] sampleFactor;
  logic       done;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  nand_timing_quantizer u_nand_timing_quantizer (
    .clk(clk), .rstN(rstN), .start(start), .periodNs(periodNs),
    .chipCount(chipCount), .dataSetupNs(dataSetupNs), .dataHoldNs(dataHoldNs),
    .addrSetupNs(addrSetupNs), .sampleDelayNs(sampleDelayNs),
    .dataSetupCyc(dataSetupCyc), .dataHoldCyc(dataHoldCyc),
    .addrSetupCyc(addrSetupCyc), .halfPeriod(halfPeriod),
    .sampleFactor(sampleFactor), .done(done)
  );

  typedef struct packed {
    logic [7:0] per;
    logic [2:0] chips;
    logic [7:0] dsNs, dhNs, asNs, sdNs;
    logic [7:0] eDs, eDh, eAs;
    logic       eHalf;
    logic [3:0] eSdf;
    logic [8:0] eK;
  } vec_t;

  // period, chips, setup, hold, addr, sample | setup, hold, addr, half, factor, passes
  localparam vec_t VECS [10] = '{
    '{8'd10, 3'd1, 8'd20,  8'd10, 8'd0,  8'd6,   8'd2,   8'd1,  8'd0,  1'b0, 4'd5,  9'd0},
    '{8'd10, 3'd2, 8'd15,  8'd0,  8'd3,  8'd0,   8'd2,   8'd1,  8'd1,  1'b0, 4'd0,  9'd0},
    '{8'd20, 3'd4, 8'd0,   8'd0,  8'd0,  8'd30,  8'd2,   8'd1,  8'd1,  1'b1, 4'd8,  9'd1},
    '{8'd40, 3'd1, 8'd100, 8'd41, 8'd80, 8'd50,  8'd5,   8'd2,  8'd2,  1'b1, 4'd0,  9'd2},
    '{8'd8,  3'd1, 8'd0,   8'd0,  8'd0,  8'd16,  8'd2,   8'd1,  8'd0,  1'b0, 4'd8,  9'd1},
    '{8'd1,  3'd3, 8'd255, 8'd0,  8'd0,  8'd200, 8'd255, 8'd10, 8'd10, 1'b0, 4'd15, 9'd0},
    '{8'd16, 3'd0, 8'd16,  8'd17, 8'd33, 8'd20,  8'd2,   8'd2,  8'd3,  1'b0, 4'd2,  9'd1},
    '{8'd17, 3'd1, 8'd17,  8'd18, 8'd1,  8'd5,   8'd1,   8'd2,  8'd1,  1'b1, 4'd5,  9'd0},
    '{8'd32, 3'd1, 8'd64,  8'd65, 8'd0,  8'd40,  8'd3,   8'd3,  8'd0,  1'b1, 4'd4,  9'd1},
    '{8'd33, 3'd1, 8'd33,  8'd1,  8'd34, 8'd0,   8'd1,   8'd1,  8'd2,  1'b1, 4'd0,  9'd0}
  };

  localparam int BASE_LAT = 61;

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    periodNs      = v.per;
    chipCount     = v.chips;
    dataSetupNs   = v.dsNs;
    dataHoldNs    = v.dhNs;
    addrSetupNs   = v.asNs;
    sampleDelayNs = v.sdNs;
  endtask

  // returns edges from the start-sampling edge to the done cycle
  task automatic waitDone(output int lat);
    int j = 1;
    while (!done && j < 1000) begin
      @(negedge clk);
      j++;
    end
    lat = j - 1;
  endtask

  task automatic checkResults(input vec_t v, input int lat);
    chk("R8 latency", lat, BASE_LAT + int'(v.eK));
    chk("R8 done", int'(done), 1);
    chk("R3/R6 data setup", int'(dataSetupCyc), int'(v.eDs));
    chk("R2/R3 data hold", int'(dataHoldCyc), int'(v.eDh));
    chk("R2/R3 address setup", int'(addrSetupCyc), int'(v.eAs));
    chk("R4 half period", int'(halfPeriod), int'(v.eHalf));
    chk("R5/R7 sample factor", int'(sampleFactor), int'(v.eSdf));
  endtask

  initial begin
    #(4 * 200000);
    nFails++;
    nChecks++;
    $display("FAIL R8 watchdog: actual no finish expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 done in reset", int'(done), 0);
    chk("R1 outputs in reset", int'({dataSetupCyc, dataHoldCyc, addrSetupCyc, halfPeriod, sampleFactor}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 outputs after reset", int'({dataSetupCyc, dataHoldCyc, addrSetupCyc, halfPeriod, sampleFactor}), 0);
    chk("R1 done after reset", int'(done), 0);

    for (int i = 0; i < 10; i++) begin
      apply(VECS[i]);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      waitDone(lat);
      checkResults(VECS[i], lat);
      @(negedge clk);
      chk("R8 done single cycle", int'(done), 0);
      repeat (3) @(negedge clk);
    end

    // R9: start during a run is ignored; input changes after start have no effect
    apply(VECS[0]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    apply(VECS[5]);
    repeat (4) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 6;
    while (!done && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    chk("R9 latency unchanged by second start", lat - 1, BASE_LAT);
    chk("R9 setup from first inputs", int'(dataSetupCyc), int'(VECS[0].eDs));
    chk("R9 factor from first inputs", int'(sampleFactor), int'(VECS[0].eSdf));
    chk("R9 addr from first inputs", int'(addrSetupCyc), int'(VECS[0].eAs));

    // R8: results hold and no extra done after the run
    repeat (70) @(negedge clk);
    chk("R9/R8 no second done", int'(done), 0);
    chk("R8 hold setup", int'(dataSetupCyc), int'(VECS[0].eDs));
    chk("R8 hold hold", int'(dataHoldCyc), int'(VECS[0].eDh));
    chk("R8 hold factor", int'(sampleFactor), int'(VECS[0].eSdf));

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule